// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-driven master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software writes one 32-bit command word that already holds the whole clause-22 frame: start code, opcode, PHY and register addresses, turnaround and data. The block sends a run of preamble ones and then the 32 frame bits MSB first. MDIO changes only on MDC falling edges. For a read, the block releases MDIO from the second turnaround bit to the end of the frame and samples the 16 PHY data bits on MDC rising edges. It returns them in the low half of the command register.

When a frame ends, a sticky completion event bit is set. Software clears it by writing a one to it. The interrupt output is the event bit gated by a mask bit. MDC runs only during a frame. Its rate comes from a divider field in the control register.

The sequencer has five states. `ST_IDLE` goes to `ST_PRE` on an accepted command. `ST_PRE` goes to `ST_HDR` after the last preamble bit. `ST_HDR` goes to `ST_TA` after the 14 start/opcode/address bits. `ST_TA` goes to `ST_DATA` after the two turnaround bits. `ST_DATA` goes back to `ST_IDLE` after 16 data bits, and this last transition raises completion. Every transition takes place on an MDC falling edge, except the start from `ST_IDLE`.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write to the command register (address 0), when the block is idle, the enable bit is set and the divider is nonzero, stores the word and raises `busy` on the next clock.
- R2: A frame is PRE_LEN ones followed by command bits 31 down to 0. MDIO and its enable change only on MDC falling edges, never while MDC stays high.
- R3: With divider D, MDC is high for 2·D clocks and low for 2·D clocks. MDC is low while the block is idle. Each frame has exactly PRE_LEN+32 MDC rising edges.
- R4: For a read (command bits 29:28 = 10), `mdio_oe` is low from the second turnaround bit through the 16 data bits. The data is sampled on MDC rising edges, MSB first, and placed in command bits 15:0, with bits 31:16 kept.
- R5: For a write (bits 29:28 = 01), `mdio_oe` stays high for the whole frame, and the command register reads back unchanged afterwards.
- R6: Completion sets event bit 23 at address 1, on the same clock that `busy` falls. Writing 1 to that bit clears it. Writing 0 leaves it set.
- R7: `irq` is high exactly when event bit 23 and mask bit 23 (address 2) are both set.
- R8: When enable bit 0 of the control register (address 3) is clear, a command write is ignored: no frame, no `busy`, and the register keeps its old value.
- R9: The divider sits in control bits 6:1. A divider of 0 blocks any command write, and MDC stays low.
- R10: A command write while `busy` is high is dropped. The register and the frame in flight are unaffected.
- R11: After reset, all registers read 0, and `mdc`, `mdio_oe`, `busy` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 event, 2 mask, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value from the pad |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Event bit gated by mask |

## Verification
The bench builds the block with PRE_LEN = 8 and the default 6-bit divider field. The short preamble keeps each frame near 40 MDC periods. That leaves room to run reads and writes at dividers 1, 2 and 3, and also the dropped-command, disabled, zero-divider and event-clear cases. A small PHY responder in the bench logs every bit at MDC rising edges and supplies read data. This lets the bench check the preamble count, the turnaround release point, the MDC high and low times, and the data captured into the register.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mgmt_st_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] A_CMD    = 2'd0;
    localparam logic [1:0] A_EVT    = 2'd1;
    localparam logic [1:0] A_MASK   = 2'd2;
    localparam logic [1:0] A_CTRL   = 2'd3;
    localparam int         EVT_BIT  = 23;
    localparam int         HDR_BITS = 14;
    localparam int         TA_BITS  = 2;
    localparam int         DAT_BITS = 16;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             tick_rise,
    output logic             tick_fall
);
    logic [DIV_W-1:0] div_lat;
    logic [DIV_W:0]   cnt_q;
    logic [DIV_W:0]   lim;
    logic             at_lim;

    // half period is 2*div system clocks
    assign lim    = {div_lat, 1'b0} - (DIV_W+1)'(1);
    assign at_lim = run && (cnt_q == lim);
    assign tick_rise = at_lim && !mdc;
    assign tick_fall = at_lim && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mdc     <= 1'b0;
            div_lat <= '0;
        end else if (!run) begin
            cnt_q   <= '0;
            mdc     <= 1'b0;
            div_lat <= div;
        end else if (at_lim) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] cmd,
    input  logic        tick_rise,
    input  logic        tick_fall,
    input  logic        mdio_in,
    output mgmt_st_e    state_q,
    output logic        run,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_word
);
    localparam int CNT_W = $clog2((PRE_LEN > DAT_BITS) ? PRE_LEN : DAT_BITS);

    mgmt_st_e         nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      sh_q;
    logic             rd_q;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start) nxt = ST_PRE;
            ST_PRE:  if (tick_fall && cnt_q == CNT_W'(PRE_LEN-1))  nxt = ST_HDR;
            ST_HDR:  if (tick_fall && cnt_q == CNT_W'(HDR_BITS-1)) nxt = ST_TA;
            ST_TA:   if (tick_fall && cnt_q == CNT_W'(TA_BITS-1))  nxt = ST_DATA;
            ST_DATA: if (tick_fall && cnt_q == CNT_W'(DAT_BITS-1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            rd_q    <= 1'b0;
            rd_word <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                cnt_q <= '0;
                sh_q  <= cmd;
                rd_q  <= (cmd[29:28] == OP_READ);
            end else if (tick_fall) begin
                cnt_q <= (nxt != state_q) ? '0 : cnt_q + 1'b1;
                if (state_q != ST_PRE) sh_q <= {sh_q[30:0], 1'b0};
            end
            if (tick_rise && state_q == ST_DATA && rd_q)
                rd_word <= {rd_word[14:0], mdio_in};
        end
    end

    always_comb begin
        run    = (state_q != ST_IDLE);
        done   = tick_fall && (state_q == ST_DATA) && (cnt_q == CNT_W'(DAT_BITS-1));
        mdio_o = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin mdio_o = 1'b1;     mdio_oe = 1'b0; end
            ST_PRE:  begin mdio_o = 1'b1;     mdio_oe = 1'b1; end
            ST_HDR:  begin mdio_o = sh_q[31]; mdio_oe = 1'b1; end
            ST_TA:   begin mdio_o = sh_q[31]; mdio_oe = !(rd_q && cnt_q == CNT_W'(1)); end
            ST_DATA: begin mdio_o = sh_q[31]; mdio_oe = !rd_q; end
            default: begin mdio_o = 1'b1;     mdio_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DIV_W   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in,
    output logic        busy,
    output logic        irq
);
    logic [31:0]      cmd_q;
    logic             evt_q;
    logic             mask_q;
    logic             mode_en_q;
    logic [DIV_W-1:0] div_q;
    logic             start;
    logic             run;
    logic             done;
    logic             tick_rise;
    logic             tick_fall;
    logic [15:0]      rd_word;
    mgmt_st_e         fsm_state;

    assign start = reg_wr && (reg_addr == A_CMD) && mode_en_q && (div_q != '0) && !busy;
    assign busy  = run;
    assign irq   = evt_q && mask_q;

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
        .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(reg_wdata),
        .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_in(mdio_in),
        .state_q(fsm_state), .run(run), .mdio_o(mdio_out), .mdio_oe(mdio_oe),
        .done(done), .rd_word(rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            evt_q     <= 1'b0;
            mask_q    <= 1'b0;
            mode_en_q <= 1'b0;
            div_q     <= '0;
        end else begin
            if (start)
                cmd_q <= reg_wdata;
            else if (done && cmd_q[29:28] == OP_READ)
                cmd_q[15:0] <= rd_word;

            if (done)
                evt_q <= 1'b1;
            else if (reg_wr && reg_addr == A_EVT && reg_wdata[EVT_BIT])
                evt_q <= 1'b0;

            if (reg_wr && reg_addr == A_MASK)
                mask_q <= reg_wdata[EVT_BIT];

            if (reg_wr && reg_addr == A_CTRL) begin
                mode_en_q <= reg_wdata[0];
                div_q     <= reg_wdata[DIV_W:1];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CMD:  reg_rdata = cmd_q;
            A_EVT:  reg_rdata[EVT_BIT] = evt_q;
            A_MASK: reg_rdata[EVT_BIT] = mask_q;
            A_CTRL: begin
                reg_rdata[0]       = mode_en_q;
                reg_rdata[DIV_W:1] = div_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             busy,
    input logic             irq,
    input mgmt_st_e         fsm_state,
    input logic [31:0]      cmd_q,
    input logic             evt_q,
    input logic             mask_q,
    input logic             mode_en_q,
    input logic [DIV_W-1:0] div_q
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && mode_en_q && div_q != '0 && !busy) |=> busy); // R1
    AST_MDIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R2
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R3
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DATA && cmd_q[29:28] == OP_READ) |-> !mdio_oe); // R4
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_q[29:28] != OP_READ) |-> mdio_oe); // R5
    AST_EVT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt_q); // R6
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !(reg_wr && reg_addr == A_EVT && reg_wdata[EVT_BIT])) |=> evt_q); // R6
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (mask_q && evt_q)); // R7
    AST_NO_START_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && !mode_en_q && !busy) |=> !busy); // R8
    AST_NO_START_DIV0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && div_q == '0 && !busy) |=> !busy); // R9
    AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_CMD) |=> (cmd_q[31:16] == $past(cmd_q[31:16]))); // R10
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;
    localparam int PRE = 8;
    localparam int NV  = 6;
    // {rd, phy[5], reg[5], div[6], data[16]}
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 5'h01, 5'h02, 6'd1, 16'h1234},
        {1'b0, 5'h1F, 5'h00, 6'd1, 16'hA5A5},
        {1'b1, 5'h00, 5'h1F, 6'd2, 16'hFFFF},
        {1'b0, 5'h0A, 5'h15, 6'd3, 16'h0001},
        {1'b1, 5'h10, 5'h04, 6'd1, 16'h8001},
        {1'b0, 5'h03, 5'h09, 6'd2, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe, busy, irq;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic        bitlog [64];
    logic        oelog  [64];
    int          nrise = 0;
    logic [15:0] resp = '0;
    time         t_r0, t_r1, t_f0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl #(.PRE_LEN(PRE), .DIV_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
        .busy(busy), .irq(irq)
    );

    // PHY-side logger and responder
    always @(posedge mdc) begin
        if (nrise < 64) begin
            bitlog[nrise] = mdio_out;
            oelog[nrise]  = mdio_oe;
        end
        if (nrise == 0) t_r0 = $time;
        if (nrise == 1) t_r1 = $time;
        nrise = nrise + 1;
    end
    always @(negedge mdc) begin
        if (nrise == 1) t_f0 = $time;
        if (nrise >= PRE + 16 && nrise < PRE + 32)
            mdio_in = resp[15 - (nrise - (PRE + 16))];
        else
            mdio_in = 1'b1;
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_cmd(input logic [32:0] v);
        return {2'b01, v[32] ? 2'b10 : 2'b01, v[31:27], v[26:22], 2'b10, v[32] ? 16'h0 : v[15:0]};
    endfunction

    task automatic check_frame(input logic [31:0] cmd, input bit is_rd);
        logic [31:0] obs, oem;
        bit pre_ok;
        pre_ok = 1;
        for (int i = 0; i < PRE; i++) if (!(bitlog[i] === 1'b1 && oelog[i] === 1'b1)) pre_ok = 0;
        chk(pre_ok, "R2 preamble ones", 32'(pre_ok), 32'd1);
        for (int k = 0; k < 32; k++) begin
            obs[31-k] = bitlog[PRE+k];
            oem[31-k] = oelog[PRE+k];
        end
        chk(nrise == PRE + 32, "R3 rising edge count", 32'(nrise), 32'(PRE + 32));
        if (is_rd) begin
            chk(obs[31:17] == cmd[31:17], "R2 read header bits", {17'b0, obs[31:17]}, {17'b0, cmd[31:17]});
            chk(oem == 32'hFFFE_0000, "R4 release window", oem, 32'hFFFE_0000);
        end else begin
            chk(obs == cmd, "R2 write frame bits", obs, cmd);
            chk(oem == 32'hFFFF_FFFF, "R5 drive whole frame", oem, 32'hFFFF_FFFF);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=busy expected=done");
        summary();
    end

    initial begin
        logic [31:0] d, cmd, cmd_a, cmd_b, prev;
        repeat (3) @(negedge clk);
        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk(d == 32'h0, "R11 register reset", d, 32'h0);
        end
        chk({mdc, mdio_oe, busy, irq} == 4'b0, "R11 output reset", {28'b0, mdc, mdio_oe, busy, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        wr(2'd2, 32'h0080_0000);   // mask bit 23

        // table of transactions
        for (int v = 0; v < NV; v++) begin
            cmd  = mk_cmd(VEC[v]);
            resp = VEC[v][15:0];
            wr(2'd3, {25'b0, VEC[v][21:16], 1'b1});
            nrise = 0;
            wr(2'd0, cmd);
            chk(busy === 1'b1, "R1 busy after command", {31'b0, busy}, 32'd1);
            rd(2'd1, d);
            chk(d == 32'h0, "R6 event clear while busy", d, 32'h0);
            wait_idle();
            check_frame(cmd, VEC[v][32]);
            chk(t_r1 - t_r0 == 32 * VEC[v][21:16], "R3 mdc period", 32'(t_r1 - t_r0), 32'(32 * VEC[v][21:16]));
            chk(t_f0 - t_r0 == 16 * VEC[v][21:16], "R3 mdc high time", 32'(t_f0 - t_r0), 32'(16 * VEC[v][21:16]));
            chk(mdc === 1'b0, "R3 mdc low idle", {31'b0, mdc}, 32'd0);
            rd(2'd0, d);
            if (VEC[v][32])
                chk(d == {cmd[31:16], resp}, "R4 read data captured", d, {cmd[31:16], resp});
            else
                chk(d == cmd, "R5 write reg unchanged", d, cmd);
            rd(2'd1, d);
            chk(d == 32'h0080_0000, "R6 event set", d, 32'h0080_0000);
            chk(irq === 1'b1, "R7 irq with mask", {31'b0, irq}, 32'd1);
            wr(2'd1, 32'h0080_0000);
            rd(2'd1, d);
            chk(d == 32'h0, "R6 write one clears", d, 32'h0);
            chk(irq === 1'b0, "R7 irq cleared", {31'b0, irq}, 32'd0);
        end

        // R6 writing zero keeps the event; R7 mask off hides it
        wr(2'd3, {25'b0, 6'd1, 1'b1});
        nrise = 0;
        resp = 16'h0;
        cmd = mk_cmd({1'b0, 5'h02, 5'h03, 6'd1, 16'h5A5A});
        wr(2'd0, cmd);
        wait_idle();
        wr(2'd1, 32'h0);
        rd(2'd1, d);
        chk(d == 32'h0080_0000, "R6 write zero no effect", d, 32'h0080_0000);
        wr(2'd2, 32'h0);
        chk(irq === 1'b0, "R7 masked event no irq", {31'b0, irq}, 32'd0);
        wr(2'd2, 32'h0080_0000);
        chk(irq === 1'b1, "R7 unmask raises irq", {31'b0, irq}, 32'd1);
        wr(2'd1, 32'h0080_0000);

        // R10 command while busy is dropped
        wr(2'd3, {25'b0, 6'd3, 1'b1});
        cmd_a = mk_cmd({1'b0, 5'h11, 5'h07, 6'd3, 16'hC3C3});
        cmd_b = mk_cmd({1'b0, 5'h06, 5'h1A, 6'd3, 16'h3C3C});
        nrise = 0;
        wr(2'd0, cmd_a);
        repeat (20) @(negedge clk);
        wr(2'd0, cmd_b);
        rd(2'd0, d);
        chk(d == cmd_a, "R10 register kept while busy", d, cmd_a);
        chk(busy === 1'b1, "R10 frame continues", {31'b0, busy}, 32'd1);
        wait_idle();
        check_frame(cmd_a, 1'b0);
        wr(2'd1, 32'h0080_0000);
        prev = cmd_a;

        // R8 disabled mode ignores command
        wr(2'd3, {25'b0, 6'd1, 1'b0});
        nrise = 0;
        wr(2'd0, cmd_b);
        chk(busy === 1'b0, "R8 no busy when disabled", {31'b0, busy}, 32'd0);
        repeat (20) @(negedge clk);
        chk(nrise == 0, "R8 no mdc when disabled", 32'(nrise), 32'd0);
        rd(2'd0, d);
        chk(d == prev, "R8 register unchanged", d, prev);

        // R9 zero divider blocks command
        wr(2'd3, {25'b0, 6'd0, 1'b1});
        nrise = 0;
        wr(2'd0, cmd_b);
        chk(busy === 1'b0, "R9 no busy with divider 0", {31'b0, busy}, 32'd0);
        repeat (20) @(negedge clk);
        chk(nrise == 0 && mdc === 1'b0, "R9 mdc stays low", 32'(nrise), 32'd0);
        rd(2'd0, d);
        chk(d == prev, "R9 register unchanged", d, prev);
        rd(2'd3, d);
        chk(d == 32'h1, "R9 control readback", d, 32'h1);

        summary();
    end
endmodule